// File: doc/BRIEF.md
# S/T Loop Activation Controller

This block sequences the activation of one basic-rate S/T line endpoint. A static strap picks the role: network side (NT) or terminal side (TE). A line receiver hands the block a decoded code for the INFO signal it currently sees, together with a frame-sync flag and a multiframe-sync flag. From these and a software activation request, the block chooses which INFO signal the line transmitter sends.

It presents two 4-bit nibbles. The status nibble is read-only and reports the active loop, errors, multiframe sync and frame sync. The control nibble is read/write, and bit 3 of it is the activation request. Line coding, frame detection, timers and the D-channel are handled elsewhere.

INFO codes on `rx_info` and `tx_info` use the value n for INFO n (0 to 4). The codes 5, 6 and 7 are invalid; 7 is the canonical invalid code. All state changes on a rising edge of `clk`. The status nibble is {bit3 activation, bit2 error, bit1 multiframe, bit0 frame sync}.

Top module: `st_loop_act`

## Requirements
- R1: After a hardware reset (`rst` high at an edge), `tx_info` is INFO 0 (code 0), and both the status and control nibbles read 0.
- R2: NT role (`mode_te`=0): from idle, control bit 3 set or a received INFO 1 (code 1) makes `tx_info` INFO 2 (code 2) after the next edge. While sending INFO 2, a received INFO 3 (code 3) makes the block send INFO 4 (code 4) and enter the active state. Other received codes leave the level unchanged.
- R3: TE role (`mode_te`=1): from idle, only control bit 3 starts activation, and the block sends INFO 1. While sending INFO 1, a received INFO 2 moves it to send INFO 3. While sending INFO 3, a received INFO 4 enters the active state, and the block keeps sending INFO 3. A received INFO 1 has no effect in TE idle.
- R4: Status bit 3 is 1 exactly while the block is in the active state: sending INFO 4 in NT, or sending INFO 3 after INFO 4 has been received in TE.
- R5: Status bit 2 rises after any edge at which the block was already active and `frame_sync` was 0 (error event 1). It falls after the first edge with `frame_sync` at 1 (recovery, error event 2). It is never 1 outside the active state.
- R6: In TE role, status bit 1 equals `mf_sync` as sampled at the previous edge. In NT role it always reads 0.
- R7: Status bit 0 equals `frame_sync` as sampled at the previous edge.
- R8: A write (`ctl_we`=1) loads `ctl_wdata` into the control nibble at the edge. At any edge where the block is already active, control bit 3 is cleared, and the clear wins over a simultaneous write of 1 to that bit. Bits 2..0 keep the written value.
- R9: `sw_rst` high at an edge has the same effect as `rst`: idle, INFO 0, both nibbles 0.
- R10: Once active, the transmitted level stays constant until a reset, including while the error indication is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| sw_rst | input | 1 | Synchronous software reset, same effect as rst |
| mode_te | input | 1 | Role strap: 0 network side, 1 terminal side |
| rx_info | input | 3 | Decoded received INFO code |
| frame_sync | input | 1 | Frame synchronization held |
| mf_sync | input | 1 | Multiframe synchronization held |
| ctl_we | input | 1 | Control nibble write strobe |
| ctl_wdata | input | 4 | Control nibble write data |
| tx_info | output | 3 | INFO code to transmit |
| stat_nib | output | 4 | Status nibble {act, err, mf, fs} |
| ctl_nib | output | 4 | Control nibble readback |

## Verification
Two things can land on the same edge for control bit 3: a software write that sets it, and the hardware clear caused by the active state. The bench provokes this by writing 1 to bit 3 in cycles where the loop is already active. It expects bit 3 to read 0 afterwards while bits 2..0 take the written data. A second overlap is a frame-sync drop on the very edge that enters the active state; the bench expects no error on that edge and the error one edge later. Random segments repeat both overlaps many times, under each role.

// File: rtl/st_act_pkg.sv
package st_act_pkg;

    localparam int INFO_W  = 3;
    localparam int NIB_W   = 4;
    localparam int AR_BIT  = 3;
    localparam int ACT_BIT = 3;
    localparam int ERR_BIT = 2;
    localparam int MF_BIT  = 1;
    localparam int FS_BIT  = 0;

    typedef enum logic [INFO_W-1:0] {
        INFO0   = 3'd0,
        INFO1   = 3'd1,
        INFO2   = 3'd2,
        INFO3   = 3'd3,
        INFO4   = 3'd4,
        INFO_BAD = 3'd7
    } info_t;

    typedef enum logic [2:0] {
        S_IDLE     = 3'd0,
        S_NT_WAKE  = 3'd1,
        S_TE_REQ   = 3'd2,
        S_TE_ALIGN = 3'd3,
        S_ACTIVE   = 3'd4
    } loop_st_t;

    typedef struct packed {
        logic act;
        logic err;
        logic mf;
        logic fs;
    } stat_t;

    function automatic info_t decode_info(input logic [INFO_W-1:0] code);
        case (code)
            3'd0:    return INFO0;
            3'd1:    return INFO1;
            3'd2:    return INFO2;
            3'd3:    return INFO3;
            3'd4:    return INFO4;
            default: return INFO_BAD;
        endcase
    endfunction

    function automatic info_t level_of(input loop_st_t st, input logic te);
        case (st)
            S_IDLE:     return INFO0;
            S_NT_WAKE:  return INFO2;
            S_TE_REQ:   return INFO1;
            S_TE_ALIGN: return INFO3;
            S_ACTIVE:   return te ? INFO3 : INFO4;
            default:    return INFO0;
        endcase
    endfunction

    function automatic loop_st_t nt_step(input loop_st_t st, input info_t rx,
                                         input logic ar);
        loop_st_t nx;
        nx = st;
        case (st)
            S_IDLE:    if (ar || rx == INFO1) nx = S_NT_WAKE;
            S_NT_WAKE: if (rx == INFO3)       nx = S_ACTIVE;
            S_ACTIVE:  nx = S_ACTIVE;
            default:   nx = S_IDLE;
        endcase
        return nx;
    endfunction

    function automatic loop_st_t te_step(input loop_st_t st, input info_t rx,
                                         input logic ar);
        loop_st_t nx;
        nx = st;
        case (st)
            S_IDLE:     if (ar)          nx = S_TE_REQ;
            S_TE_REQ:   if (rx == INFO2) nx = S_TE_ALIGN;
            S_TE_ALIGN: if (rx == INFO4) nx = S_ACTIVE;
            S_ACTIVE:   nx = S_ACTIVE;
            default:    nx = S_IDLE;
        endcase
        return nx;
    endfunction

endpackage

// File: rtl/st_ctrl_nib.sv
module st_ctrl_nib
    import st_act_pkg::*;
#(
    parameter int W   = NIB_W,
    parameter int ARB = AR_BIT
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sw_rst,
    input  logic         we,
    input  logic [W-1:0] wdata,
    input  logic         active,
    output logic [W-1:0] ctl,
    output logic         ar
);

    logic [W-1:0] ctl_q;
    logic [W-1:0] ctl_d;

    always_comb begin
        ctl_d = ctl_q;
        if (we) begin
            ctl_d = wdata;
        end
        if (active) begin
            ctl_d[ARB] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || sw_rst) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign ctl = ctl_q;
    assign ar  = ctl_q[ARB];

    AST_AR_SELF_CLEAR: assert property (@(posedge clk) disable iff (rst)
        active |=> !ctl_q[ARB]) else $error("request survived active"); // R8

    AST_LOW_BITS_WRITE: assert property (@(posedge clk) disable iff (rst || sw_rst)
        we |=> ctl_q[ARB-1:0] == $past(wdata[ARB-1:0])) else $error("write lost"); // R8

endmodule

// File: rtl/st_act_fsm.sv
module st_act_fsm
    import st_act_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               sw_rst,
    input  logic               mode_te,
    input  logic [INFO_W-1:0]  rx_code,
    input  logic               ar,
    input  logic               frame_sync,
    output logic [INFO_W-1:0]  tx_code,
    output logic               active,
    output logic               err
);

    loop_st_t st_q;
    loop_st_t st_d;
    loop_st_t st_nt;
    loop_st_t st_te;
    info_t    rx;
    logic     err_q;
    logic     err_d;

    assign rx    = decode_info(rx_code);
    assign st_nt = nt_step(st_q, rx, ar);
    assign st_te = te_step(st_q, rx, ar);

    always_comb begin
        st_d = mode_te ? st_te : st_nt;
    end

    // Error tracks sync loss only once the loop has been active for a cycle
    always_comb begin
        err_d = 1'b0;
        if (st_q == S_ACTIVE) begin
            err_d = !frame_sync;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || sw_rst) begin
            st_q  <= S_IDLE;
            err_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            err_q <= err_d;
        end
    end

    assign tx_code = level_of(st_q, mode_te);
    assign active  = (st_q == S_ACTIVE);
    assign err     = err_q;

    AST_ACTIVE_STICKY: assert property (@(posedge clk) disable iff (rst || sw_rst)
        active |=> active) else $error("left active without reset"); // R10

    AST_ERR_RISE_CAUSE: assert property (@(posedge clk) disable iff (rst || sw_rst)
        $rose(err_q) |-> $past(!frame_sync)) else $error("error without sync loss"); // R5

    AST_IDLE_EXIT_CAUSE: assert property (@(posedge clk) disable iff (rst || sw_rst)
        (st_q == S_IDLE && !ar && (mode_te || rx != INFO1)) |=> st_q == S_IDLE)
        else $error("idle left without request"); // R3

endmodule

// File: rtl/st_status_nib.sv
module st_status_nib
    import st_act_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             sw_rst,
    input  logic             mode_te,
    input  logic             frame_sync,
    input  logic             mf_sync,
    input  logic             active,
    input  logic             err,
    output logic [NIB_W-1:0] stat
);

    logic  fs_q;
    logic  mf_q;
    stat_t s;

    always_ff @(posedge clk) begin
        if (rst || sw_rst) begin
            fs_q <= 1'b0;
            mf_q <= 1'b0;
        end else begin
            fs_q <= frame_sync;
            mf_q <= mode_te & mf_sync;
        end
    end

    always_comb begin
        s.act = active;
        s.err = err;
        s.mf  = mf_q;
        s.fs  = fs_q;
    end

    assign stat = s;

    AST_NT_NO_MF: assert property (@(posedge clk) disable iff (rst)
        !mode_te |=> !stat[MF_BIT]) else $error("mf set in NT"); // R6

endmodule

// File: rtl/st_loop_act.sv
module st_loop_act
    import st_act_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        sw_rst,
    input  logic        mode_te,
    input  logic [2:0]  rx_info,
    input  logic        frame_sync,
    input  logic        mf_sync,
    input  logic        ctl_we,
    input  logic [3:0]  ctl_wdata,
    output logic [2:0]  tx_info,
    output logic [3:0]  stat_nib,
    output logic [3:0]  ctl_nib
);

    logic active;
    logic err;
    logic ar;

    st_ctrl_nib #(.W(NIB_W), .ARB(AR_BIT)) u_ctl (
        .clk    (clk),
        .rst    (rst),
        .sw_rst (sw_rst),
        .we     (ctl_we),
        .wdata  (ctl_wdata),
        .active (active),
        .ctl    (ctl_nib),
        .ar     (ar)
    );

    st_act_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .sw_rst     (sw_rst),
        .mode_te    (mode_te),
        .rx_code    (rx_info),
        .ar         (ar),
        .frame_sync (frame_sync),
        .tx_code    (tx_info),
        .active     (active),
        .err        (err)
    );

    st_status_nib u_stat (
        .clk        (clk),
        .rst        (rst),
        .sw_rst     (sw_rst),
        .mode_te    (mode_te),
        .frame_sync (frame_sync),
        .mf_sync    (mf_sync),
        .active     (active),
        .err        (err),
        .stat       (stat_nib)
    );

    AST_ACT_LEVEL: assert property (@(posedge clk) disable iff (rst)
        stat_nib[ACT_BIT] |-> tx_info == (mode_te ? 3'd3 : 3'd4))
        else $error("active with wrong level"); // R4

    AST_ERR_NEEDS_ACT: assert property (@(posedge clk) disable iff (rst)
        stat_nib[ERR_BIT] |-> stat_nib[ACT_BIT]) else $error("error outside active"); // R5

    AST_ERR_HOLDS_TX: assert property (@(posedge clk) disable iff (rst || sw_rst)
        stat_nib[ERR_BIT] |=> $stable(tx_info)) else $error("level moved in error"); // R10

    AST_SOFT_RESET: assert property (@(posedge clk) disable iff (rst)
        sw_rst |=> (ctl_nib == 4'd0 && stat_nib == 4'd0 && tx_info == 3'd0))
        else $error("software reset incomplete"); // R9

endmodule

// File: tb/sim_st_loop_act.sv
module sim_st_loop_act;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sw_rst = 1'b0;
    logic       mode_te = 1'b0;
    logic [2:0] rx_info = 3'd0;
    logic       frame_sync = 1'b0;
    logic       mf_sync = 1'b0;
    logic       ctl_we = 1'b0;
    logic [3:0] ctl_wdata = 4'd0;
    logic [2:0] tx_info;
    logic [3:0] stat_nib;
    logic [3:0] ctl_nib;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // model state: 0 idle, 1 NT wake, 2 TE request, 3 TE align, 4 active
    int         m_st = 0;
    logic       m_err = 1'b0;
    logic       m_fs = 1'b0;
    logic       m_mf = 1'b0;
    logic [3:0] m_ctl = 4'd0;

    always #4 clk = ~clk;

    st_loop_act u0 (
        .clk(clk), .rst(rst), .sw_rst(sw_rst), .mode_te(mode_te),
        .rx_info(rx_info), .frame_sync(frame_sync), .mf_sync(mf_sync),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .tx_info(tx_info), .stat_nib(stat_nib), .ctl_nib(ctl_nib)
    );

    function automatic logic [2:0] exp_tx(input int st, input logic te);
        case (st)
            1: return 3'd2;
            2: return 3'd1;
            3: return 3'd3;
            4: return te ? 3'd3 : 3'd4;
            default: return 3'd0;
        endcase
    endfunction

    function automatic int next_st(input int st, input logic te, input logic [2:0] rx,
                                   input logic ar);
        if (!te) begin
            if (st == 0 && (ar || rx == 3'd1)) return 1;
            if (st == 1 && rx == 3'd3) return 4;
        end else begin
            if (st == 0 && ar) return 2;
            if (st == 2 && rx == 3'd2) return 3;
            if (st == 3 && rx == 3'd4) return 4;
        end
        return st;
    endfunction

    task automatic model_edge();
        logic [3:0] c;
        if (rst || sw_rst) begin
            m_st = 0; m_err = 0; m_fs = 0; m_mf = 0; m_ctl = 0;
        end else begin
            c = ctl_we ? ctl_wdata : m_ctl;
            if (m_st == 4) c[3] = 1'b0;
            m_err = (m_st == 4) && !frame_sync;
            m_st  = next_st(m_st, mode_te, rx_info, m_ctl[3]);
            m_ctl = c;
            m_fs  = frame_sync;
            m_mf  = mode_te & mf_sync;
        end
    endtask

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    task automatic compare_all(input string ctx);
        check({ctx, " R2/R3 tx"}, tx_info, exp_tx(m_st, mode_te));
        check({ctx, " R4 act"}, stat_nib[3], (m_st == 4));
        check({ctx, " R5 err"}, stat_nib[2], m_err);
        check({ctx, " R6 mf"}, stat_nib[1], m_mf);
        check({ctx, " R7 fs"}, stat_nib[0], m_fs);
        check({ctx, " R8 ctl"}, ctl_nib, m_ctl);
    endtask

    task automatic step(input string ctx);
        @(posedge clk);
        model_edge();
        cycles++;
        @(negedge clk);
        compare_all(ctx);
        ctl_we = 1'b0;
        rst = 1'b0;
        sw_rst = 1'b0;
    endtask

    task automatic do_reset(input logic te);
        mode_te = te; rst = 1'b1; frame_sync = 1'b1; mf_sync = 1'b0; rx_info = 3'd0;
        step("R1 reset");
    endtask

    task automatic write_ctl(input logic [3:0] d);
        ctl_we = 1'b1; ctl_wdata = d;
    endtask

    initial begin
        logic [3:0] tx_hold;
        @(negedge clk);

        // NT via request
        do_reset(1'b0);
        check("R1 tx", tx_info, 0);
        check("R1 stat", stat_nib, 0);
        check("R1 ctl", ctl_nib, 0);
        write_ctl(4'b1000); step("R8 write");
        step("R2 wake");
        check("R2 sends INFO2", tx_info, 2);
        rx_info = 3'd3; step("R2 to active");
        check("R2 sends INFO4", tx_info, 4);
        check("R4 act set", stat_nib[3], 1);
        step("R8 clear");
        check("R8 request cleared", ctl_nib[3], 0);
        // conflict: write 1 to request while active
        write_ctl(4'b1101); step("R8 conflict");
        check("R8 clear beats write", ctl_nib, 4'b0101);
        // error events
        tx_hold = {1'b0, tx_info};
        frame_sync = 1'b0; step("R5 loss");
        check("R5 err rises", stat_nib[2], 1);
        rx_info = 3'd0; step("R10 hold");
        check("R10 level held", tx_info, tx_hold[2:0]);
        frame_sync = 1'b1; step("R5 regain");
        check("R5 err falls", stat_nib[2], 0);
        sw_rst = 1'b1; step("R9 sw reset");
        check("R9 ctl", ctl_nib, 0);
        check("R9 tx", tx_info, 0);

        // NT via received INFO1
        do_reset(1'b0);
        rx_info = 3'd1; step("R2 rx info1");
        check("R2 INFO1 wakes", tx_info, 2);
        rx_info = 3'd3; frame_sync = 1'b0; step("R5 loss on entry edge");
        check("R5 no err on entry", stat_nib[2], 0);
        step("R5 loss after entry");
        check("R5 err next edge", stat_nib[2], 1);

        // TE full sequence
        do_reset(1'b1);
        rx_info = 3'd1; step("R3 info1 ignored");
        check("R3 TE idle ignores INFO1", tx_info, 0);
        write_ctl(4'b1000); rx_info = 3'd0; step("R3 req");
        step("R3 send1");
        check("R3 sends INFO1", tx_info, 1);
        rx_info = 3'd2; step("R3 info2");
        check("R3 sends INFO3", tx_info, 3);
        rx_info = 3'd4; mf_sync = 1'b1; step("R3 info4");
        check("R4 TE active", stat_nib[3], 1);
        check("R6 mf follows", stat_nib[1], 1);
        mf_sync = 1'b0; step("R6 mf loss");
        check("R6 mf cleared", stat_nib[1], 0);

        // constrained random segments
        void'($urandom(32'h5A17));
        for (int seg = 0; seg < 60; seg++) begin
            do_reset($urandom_range(0, 1));
            for (int k = 0; k < 200; k++) begin
                int r;
                r = $urandom_range(0, 9);
                rx_info = (r < 8) ? 3'($urandom_range(0, 4)) : 3'($urandom_range(5, 7));
                frame_sync = ($urandom_range(0, 9) != 0);
                mf_sync = ($urandom_range(0, 3) != 0);
                if ($urandom_range(0, 7) == 0) write_ctl(4'($urandom));
                if ($urandom_range(0, 150) == 0) sw_rst = 1'b1;
                step("rand");
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #1600000;
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule